// File: doc/BRIEF.md
# TDM Time-Slot Window Generator

This block produces a per-bit enable marking when one channel's time slot is open on a serial time-division multiplexed link. Timing comes from a frame sync pulse. The sync can be taken from any of three sources. The slot opens a bit-precise distance after the sync, which is an octet index times eight plus a bit shift. It then stays open for a programmed number of bits, from 1 to 256. The same logic serves the transmit and the receive direction: each direction instantiates its own copy.

Two modes change the timing. In continuous mode the slot never closes once it has opened. In sync-disregard mode the slot is open at once and stays open, with no sync needed. After a counter clear, the slot stays shut until the first sync has been seen. A qualified strobe marks each bit period in which data is actually moved. That happens only when the slot is open and the transfer-enable flag is set.

All counting advances only on cycles where the bit clock enable is high.

Top module: `tdm_slot_gen`

## Requirements
- R1: While reset is applied, and after it is released until a sync is seen, `win_active` and `xfer_strobe` are low (with `sync_ignore` low).
- R2: `sync_sel` values 0, 1 and 2 pick `sync_in[0]`, `sync_in[1]` and `sync_in[2]`. The value 3 picks no source. Pulses on unselected inputs have no effect on the window.
- R3: A sync is detected only on a rising edge of the selected input, sampled on `bit_en` cycles. A level held high counts once.
- R4: The bit-enable cycle that detects a sync starts the count at position 0. Each later `bit_en` cycle adds one. The window is open while the position is at least `slot_idx*8 + bit_shift`.
- R5: In normal mode the window stays open for `slot_len + 1` positions, so 0 gives 1 bit and 255 gives 256 bits. It then closes.
- R6: With `cont_mode` high, the window does not close once open, whatever `slot_len` holds.
- R7: After reset or an accepted clear, the window stays shut until the first detected sync.
- R8: With `sync_ignore` high, `win_active` is high on every cycle, whatever `cont_mode` and the sync state are.
- R9: `cnt_clr` is accepted only while `xfer_en` is low. An accepted clear shuts the window from the next cycle. While `xfer_en` is high, `cnt_clr` has no effect.
- R10: `xfer_strobe` is high exactly when `win_active`, `xfer_en` and `bit_en` are all high.
- R11: A sync detected while a window is open restarts the position count at 0. In normal mode the window then reopens at the programmed offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | Bit clock enable, one cycle per serial bit |
| sync_in | input | 3 | Frame sync candidates |
| sync_sel | input | 2 | Frame sync source select (3 = none) |
| slot_idx | input | 6 | Slot position in octets |
| bit_shift | input | 3 | Additional start offset in bits |
| slot_len | input | 8 | Slot length minus one, in bits |
| cont_mode | input | 1 | Continuous slot: never closes once open |
| sync_ignore | input | 1 | Disregard syncs; window permanently open |
| xfer_en | input | 1 | Transfer enable; also blocks the counter clear |
| cnt_clr | input | 1 | Counter clear, accepted only with xfer_en low |
| win_active | output | 1 | Slot window open |
| xfer_strobe | output | 1 | Qualified per-bit transfer strobe |

## Verification
A single sync followed by a long run of bit enables shows where the window opens and closes. Comparing short, maximum and continuous lengths separates the end-of-slot compare from the continuous override. Pulses on unselected inputs, on a selected input held high, and under select value 3 show that only rising edges of the chosen source restart timing. A second sync inside an open slot shows the restart. Randomly gapped `bit_en` shows that counting follows the enable and not the clock. Clears with `xfer_en` high and low, and toggling sync-disregard, separate the gating of the clear and the forced-open path.

// File: rtl/tdm_slot_pkg.sv
package tdm_slot_pkg;
  localparam int IDX_W_D   = 6;
  localparam int SHIFT_W_D = 3;
  localparam int LEN_W_D   = 8;
  localparam int NSYNC_D   = 3;
  localparam int SEL_W_D   = 2;
  // Position must reach idx*2^shift_w + shift + len; two spare bits leave room to saturate.
  localparam int POS_W_D   = IDX_W_D + SHIFT_W_D + 2;
endpackage

// File: rtl/tdm_sync_pick.sv
module tdm_sync_pick #(
  parameter int NSYNC = tdm_slot_pkg::NSYNC_D,
  parameter int SEL_W = tdm_slot_pkg::SEL_W_D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic [NSYNC-1:0] sync_in,
  input  logic [SEL_W-1:0] sync_sel,
  output logic             sync_edge
);
  logic [NSYNC-1:0] hit;
  logic             sync_now;
  logic             prev_q, prev_d;

  for (genvar g = 0; g < NSYNC; g++) begin : g_pick
    assign hit[g] = sync_in[g] && (sync_sel == SEL_W'(g));
  end

  assign sync_now = |hit;

  always_comb begin
    prev_d = prev_q;
    if (bit_en) prev_d = sync_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign sync_edge = bit_en && sync_now && !prev_q;

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_edge |=> !sync_edge); // R3
endmodule

// File: rtl/tdm_pos_counter.sv
module tdm_pos_counter #(
  parameter int POS_W = tdm_slot_pkg::POS_W_D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             sync_edge,
  input  logic             clr_ok,
  output logic             armed,
  output logic [POS_W-1:0] pos
);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic             armed_d;
  logic [POS_W-1:0] pos_d;

  always_comb begin
    armed_d = armed;
    pos_d   = pos;
    if (clr_ok) begin
      armed_d = 1'b0;
      pos_d   = '0;
    end else if (bit_en) begin
      if (sync_edge) begin
        armed_d = 1'b1;
        pos_d   = '0;
      end else if (armed && pos != POS_MAX) begin
        pos_d = pos + POS_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      pos   <= '0;
    end else begin
      armed <= armed_d;
      pos   <= pos_d;
    end
  end

  AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_edge && !clr_ok) |=> (armed && pos == '0)); // R11
  AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !sync_edge && !clr_ok && armed && pos != POS_MAX)
      |=> pos == $past(pos) + POS_W'(1)); // R4
  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !clr_ok) |=> ($stable(pos) && $stable(armed))); // R4
  AST_CLR_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ok |=> !armed); // R9
endmodule

// File: rtl/tdm_window_cmp.sv
module tdm_window_cmp #(
  parameter int IDX_W   = tdm_slot_pkg::IDX_W_D,
  parameter int SHIFT_W = tdm_slot_pkg::SHIFT_W_D,
  parameter int LEN_W   = tdm_slot_pkg::LEN_W_D,
  parameter int POS_W   = tdm_slot_pkg::POS_W_D
) (
  input  logic               armed,
  input  logic [POS_W-1:0]   pos,
  input  logic [IDX_W-1:0]   slot_idx,
  input  logic [SHIFT_W-1:0] bit_shift,
  input  logic [LEN_W-1:0]   slot_len,
  input  logic               cont_mode,
  input  logic               sync_ignore,
  output logic               win
);
  logic [POS_W-1:0] start_pos;
  logic [POS_W-1:0] last_pos;
  logic             past_start;
  logic             before_end;

  always_comb begin
    start_pos  = (POS_W'(slot_idx) << SHIFT_W) | POS_W'(bit_shift);
    last_pos   = start_pos + POS_W'(slot_len);
    past_start = pos >= start_pos;
    before_end = cont_mode || (pos <= last_pos);
    win        = sync_ignore || (armed && past_start && before_end);
  end
endmodule

// File: rtl/tdm_slot_gen.sv
module tdm_slot_gen #(
  parameter int IDX_W   = tdm_slot_pkg::IDX_W_D,
  parameter int SHIFT_W = tdm_slot_pkg::SHIFT_W_D,
  parameter int LEN_W   = tdm_slot_pkg::LEN_W_D,
  parameter int NSYNC   = tdm_slot_pkg::NSYNC_D,
  parameter int SEL_W   = tdm_slot_pkg::SEL_W_D
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_en,
  input  logic [NSYNC-1:0]   sync_in,
  input  logic [SEL_W-1:0]   sync_sel,
  input  logic [IDX_W-1:0]   slot_idx,
  input  logic [SHIFT_W-1:0] bit_shift,
  input  logic [LEN_W-1:0]   slot_len,
  input  logic               cont_mode,
  input  logic               sync_ignore,
  input  logic               xfer_en,
  input  logic               cnt_clr,
  output logic               win_active,
  output logic               xfer_strobe
);
  localparam int POS_W = IDX_W + SHIFT_W + 2;

  logic [1:0]       rst_q;
  logic             rst_i_n;
  logic             sync_edge;
  logic             clr_ok;
  logic             armed;
  logic [POS_W-1:0] pos;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i_n = rst_q[1];

  assign clr_ok = cnt_clr && !xfer_en;

  tdm_sync_pick #(.NSYNC(NSYNC), .SEL_W(SEL_W)) u_pick (
    .clk(clk), .rst_n(rst_i_n), .bit_en(bit_en),
    .sync_in(sync_in), .sync_sel(sync_sel), .sync_edge(sync_edge)
  );

  tdm_pos_counter #(.POS_W(POS_W)) u_cnt (
    .clk(clk), .rst_n(rst_i_n), .bit_en(bit_en), .sync_edge(sync_edge),
    .clr_ok(clr_ok), .armed(armed), .pos(pos)
  );

  tdm_window_cmp #(.IDX_W(IDX_W), .SHIFT_W(SHIFT_W), .LEN_W(LEN_W), .POS_W(POS_W)) u_cmp (
    .armed(armed), .pos(pos), .slot_idx(slot_idx), .bit_shift(bit_shift),
    .slot_len(slot_len), .cont_mode(cont_mode), .sync_ignore(sync_ignore),
    .win(win_active)
  );

  assign xfer_strobe = win_active && xfer_en && bit_en;

  AST_IGNORE_OPEN: assert property (@(posedge clk) disable iff (!rst_i_n)
    sync_ignore |-> win_active); // R8
  AST_UNARMED_SHUT: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!armed && !sync_ignore) |-> !win_active); // R7
  AST_CLR_SHUTS: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cnt_clr && !xfer_en) |=> (sync_ignore || !win_active)); // R9
  AST_STROBE_QUAL: assert property (@(posedge clk) disable iff (!rst_i_n)
    xfer_strobe |-> (win_active && xfer_en)); // R10
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_i_n |-> (!xfer_strobe && (sync_ignore || !win_active))); // R1
endmodule

// File: tb/tdm_slot_gen_bench.sv
module tdm_slot_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_en;
  logic [2:0] sync_in;
  logic [1:0] sync_sel;
  logic [5:0] slot_idx;
  logic [2:0] bit_shift;
  logic [7:0] slot_len;
  logic       cont_mode, sync_ignore, xfer_en, cnt_clr;
  logic       win_active, xfer_strobe;

  int checks = 0;
  int fails  = 0;
  string tag = "R1";

  // Reference state.
  bit m_armed;
  int m_pos;
  bit m_prev;

  always #5 clk = ~clk;

  tdm_slot_gen u_tdm_slot_gen (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sync_in(sync_in), .sync_sel(sync_sel),
    .slot_idx(slot_idx), .bit_shift(bit_shift), .slot_len(slot_len),
    .cont_mode(cont_mode), .sync_ignore(sync_ignore), .xfer_en(xfer_en),
    .cnt_clr(cnt_clr), .win_active(win_active), .xfer_strobe(xfer_strobe)
  );

  function automatic bit sel_sync();
    if (sync_sel == 2'd3) return 1'b0;
    return sync_in[sync_sel];
  endfunction

  function automatic bit exp_win();
    int start;
    if (sync_ignore) return 1'b1;
    if (!m_armed) return 1'b0;
    start = int'(slot_idx) * 8 + int'(bit_shift);
    return (m_pos >= start) && (cont_mode || (m_pos - start <= int'(slot_len)));
  endfunction

  task automatic check(input string t, input bit act, input bit exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", t, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit s;
    s = sel_sync();
    if (cnt_clr && !xfer_en) begin
      m_armed = 1'b0; m_pos = 0;
    end else if (bit_en) begin
      if (s && !m_prev) begin
        m_armed = 1'b1; m_pos = 0;
      end else if (m_armed && m_pos < 2047) begin
        m_pos++;
      end
    end
    if (bit_en) m_prev = s;
  endtask

  // Inputs were set at the negedge; check, then let the edge happen.
  task automatic cyc();
    bit ew;
    #1;
    ew = exp_win();
    check(tag, win_active, ew, "win_active");
    check("R10", xfer_strobe, ew && xfer_en && bit_en, "xfer_strobe");
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic pulse(input int which);
    sync_in[which] = 1'b1;
    cyc();
    sync_in = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; sync_in = '0; sync_sel = 2'd0;
    slot_idx = '0; bit_shift = '0; slot_len = '0;
    cont_mode = 1'b0; sync_ignore = 1'b0; xfer_en = 1'b0; cnt_clr = 1'b0;
    m_armed = 1'b0; m_pos = 0; m_prev = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    check("R1", win_active, 1'b0, "win_active in reset");
    check("R1", xfer_strobe, 1'b0, "xfer_strobe in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    tag = "R1"; bit_en = 1'b1; xfer_en = 1'b1;
    run(6);

    // R7 / R4 / R5: first sync on input 1, offset 2, length 4
    sync_sel = 2'd1; bit_shift = 3'd2; slot_len = 8'd3;
    tag = "R7"; run(5);
    tag = "R4"; pulse(1); run(12);

    // R2: unselected input, then select none
    tag = "R2"; pulse(0); run(4); pulse(2); run(4);
    sync_sel = 2'd3; pulse(0); pulse(1); pulse(2); run(10);
    sync_sel = 2'd2; pulse(2); run(8);

    // R4: octet index offset
    tag = "R4"; slot_idx = 6'd2; bit_shift = 3'd5; slot_len = 8'd1;
    pulse(2); run(28);

    // R11: restart while open
    tag = "R11"; slot_idx = 6'd1; bit_shift = 3'd0; slot_len = 8'd20;
    pulse(2); run(12); pulse(2); run(35);

    // R3: level held high, with gapped bit enable
    tag = "R3"; slot_idx = 6'd0; slot_len = 8'd2;
    sync_in[2] = 1'b1;
    for (int i = 0; i < 20; i++) begin bit_en = (i % 3) != 1; cyc(); end
    sync_in = '0; bit_en = 1'b1; run(4);

    // R6: continuous mode
    tag = "R6"; cont_mode = 1'b1; slot_idx = 6'd1; slot_len = 8'd0;
    pulse(2); run(40);

    // R9: clear blocked by xfer_en, then accepted
    tag = "R9"; cnt_clr = 1'b1; xfer_en = 1'b1; run(3);
    xfer_en = 1'b0; run(2); cnt_clr = 1'b0; run(5);
    tag = "R7"; run(6);

    // R8: sync disregard forces the window open
    tag = "R8"; sync_ignore = 1'b1; cont_mode = 1'b0; xfer_en = 1'b1; run(6);
    cnt_clr = 1'b1; xfer_en = 1'b0; run(2); cnt_clr = 1'b0; xfer_en = 1'b1; run(4);
    sync_ignore = 1'b0; tag = "R7"; run(4);

    // R5: maximum length 256
    tag = "R5"; slot_idx = 6'd0; bit_shift = 3'd0; slot_len = 8'd255; cont_mode = 1'b0;
    pulse(2); run(262);
    slot_len = 8'd0; pulse(2); run(4);

    // Constrained random mix
    void'($urandom(32'h5eed_1234));
    tag = "R4";
    for (int i = 0; i < 3000; i++) begin
      bit_en   = ($urandom % 4) != 0;
      sync_in  = (($urandom % 40) == 0) ? 3'($urandom) : 3'b000;
      if (($urandom % 200) == 0) sync_sel = 2'($urandom);
      if (($urandom % 150) == 0) begin
        slot_idx = 6'($urandom % 3); bit_shift = 3'($urandom);
        slot_len = 8'($urandom % 24);
        cont_mode = ($urandom % 5) == 0;
      end
      sync_ignore = ($urandom % 60) == 0;
      xfer_en  = ($urandom % 3) != 0;
      cnt_clr  = ($urandom % 90) == 0;
      cyc();
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule